// File: doc/BRIEF.md
# Pin Control Register Bank with Set/Clear Aliases

This block holds the software-visible state for 32 general-purpose pins. It contains an output-level register, a direction register and one 32-bit configuration word per pin. It also has a read-only input register, which samples the pin values that a separate resolver supplies. The output and direction registers can each be written three ways: replace, OR-in or clear-where-one. Every alias address reads back the same underlying register.

The direction of each pin is visible in two places: the packed direction register and bit 0 of that pin's configuration word. A write through either path is seen at once through the other. The register outputs go straight to the pin resolver, and that logic is not part of this block.

The bus is a one-cycle request port: a request is presented with `req_valid` and is always accepted, since there is no back-pressure. Read data, and an error flag for unmapped offsets, come back exactly one cycle later with `rsp_valid`. Only aligned 32-bit words are supported.

Top module: `gpio_regbank`

## Requirements
- R1: After reset, the output register, the input register and the direction register read 0, and every configuration word reads 0x00000002.
- R2: A write to offset 0x504 replaces the output register. A write to 0x508 ORs the data into it. A write to 0x50C clears the bits that are 1 in the data.
- R3: A read of 0x504, 0x508 or 0x50C returns the current output register.
- R4: Offsets 0x514 (replace), 0x518 (OR-in) and 0x51C (clear) act on the direction register in the same way as R2. A read of any of the three returns the direction register.
- R5: After any write to the direction register, bit 0 of every pin's configuration word equals that pin's direction bit.
- R6: A write to a configuration word stores all 32 bits, and its bit 0 becomes that pin's direction bit. No other pin changes.
- R7: Configuration words sit at 0x700 to 0x77C, one every 4 bytes. The pin index is (offset − 0x700)/4.
- R8: A read of 0x510 returns the pin input vector as sampled at the clock edge before the request. A write to 0x510 changes nothing and raises the error flag.
- R9: Any offset that is unmapped or not word-aligned reads as 0 and raises `rsp_err`. A write to such an offset changes no register.
- R10: `rsp_valid`, `rsp_rdata` and `rsp_err` appear exactly one cycle after the request. `rsp_err` is 0 for mapped accesses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Bus request present, always accepted |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Byte offset |
| req_wdata | input | 32 | Write data |
| pin_in | input | 32 | Resolved pin levels from the resolver |
| rsp_valid | output | 1 | Response one cycle after a request |
| rsp_rdata | output | 32 | Read data (0 for writes and errors) |
| rsp_err | output | 1 | Unmapped or illegal access |
| out_level | output | 32 | Output register to the resolver |
| dir_mask | output | 32 | Direction register to the resolver |
| cfg_words | output | 1024 | All configuration words, pin k at bits 32k+31..32k |

## Verification
A wrong internal state shows on `out_level`, `dir_mask` and `cfg_words` one cycle after the write that caused it. It also shows on `rsp_rdata` one cycle after any read of the affected offset. The hardest fault to see is a broken direction coupling, because it only appears when the state is read back through the other path. For that reason, every direction or configuration write is followed by reads through the opposite alias. An unmapped write that wrongly changes a register is caught by the port comparison on the very next cycle.

// File: rtl/gpio_regbank_pkg.sv
package gpio_regbank_pkg;
  typedef enum logic [3:0] {
    SEL_NONE, SEL_OUT, SEL_OUTSET, SEL_OUTCLR, SEL_IN,
    SEL_DIR, SEL_DIRSET, SEL_DIRCLR, SEL_CFG
  } sel_e;

  typedef enum logic [1:0] {OP_HOLD, OP_LOAD, OP_SET, OP_CLR} op_e;

  localparam logic [11:0] OFS_OUT    = 12'h504;
  localparam logic [11:0] OFS_OUTSET = 12'h508;
  localparam logic [11:0] OFS_OUTCLR = 12'h50C;
  localparam logic [11:0] OFS_IN     = 12'h510;
  localparam logic [11:0] OFS_DIR    = 12'h514;
  localparam logic [11:0] OFS_DIRSET = 12'h518;
  localparam logic [11:0] OFS_DIRCLR = 12'h51C;
  localparam logic [11:0] OFS_CFG    = 12'h700;
endpackage

// File: rtl/gpio_addr_decode.sv
module gpio_addr_decode
  import gpio_regbank_pkg::*;
#(
  parameter int AW    = 12,
  parameter int NPINS = 32,
  localparam int IW   = (NPINS > 1) ? $clog2(NPINS) : 1
) (
  input  logic [AW-1:0] addr,
  output sel_e          sel,
  output logic [IW-1:0] cfg_idx
);
  localparam int CFG_SPAN = 4 * NPINS;

  logic [AW-1:0] cfg_off;

  assign cfg_off = addr - AW'(OFS_CFG);
  assign cfg_idx = cfg_off[IW+1:2];

  always_comb begin
    sel = SEL_NONE;
    if (addr[1:0] == 2'b00) begin
      if (addr >= AW'(OFS_CFG) && int'(cfg_off) < CFG_SPAN) sel = SEL_CFG;
      else begin
        case (addr)
          AW'(OFS_OUT):    sel = SEL_OUT;
          AW'(OFS_OUTSET): sel = SEL_OUTSET;
          AW'(OFS_OUTCLR): sel = SEL_OUTCLR;
          AW'(OFS_IN):     sel = SEL_IN;
          AW'(OFS_DIR):    sel = SEL_DIR;
          AW'(OFS_DIRSET): sel = SEL_DIRSET;
          AW'(OFS_DIRCLR): sel = SEL_DIRCLR;
          default:         sel = SEL_NONE;
        endcase
      end
    end
  end
endmodule

// File: rtl/gpio_setclr_reg.sv
module gpio_setclr_reg
  import gpio_regbank_pkg::*;
#(
  parameter int W     = 32,
  localparam int IW   = (W > 1) ? $clog2(W) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  op_e           op,
  input  logic [W-1:0]  data,
  input  logic          bit_we,
  input  logic [IW-1:0] bit_idx,
  input  logic          bit_val,
  output logic [W-1:0]  q
);
  logic [W-1:0] q_n;

  always_comb begin
    q_n = q;
    case (op)
      OP_LOAD: q_n = data;
      OP_SET:  q_n = q | data;
      OP_CLR:  q_n = q & ~data;
      default: q_n = q;
    endcase
    if (bit_we) q_n[bit_idx] = bit_val;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) q <= '0;
    else        q <= q_n;
  end

  assert_set_hits_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_SET && !bit_we) |=> ((q & $past(data)) == $past(data)));
  assert_clr_hits_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_CLR && !bit_we) |=> ((q & $past(data)) == '0));
  assert_hold_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_HOLD && !bit_we) |=> $stable(q));
endmodule

// File: rtl/gpio_cfg_array.sv
module gpio_cfg_array #(
  parameter int NPINS = 32,
  localparam int IW   = (NPINS > 1) ? $clog2(NPINS) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   we,
  input  logic [IW-1:0]          idx,
  input  logic [30:0]            wdata_hi,
  output logic [NPINS-1:0][30:0] hi_q
);
  for (genvar k = 0; k < NPINS; k++) begin : g_pin
    always_ff @(posedge clk) begin
      if (!rst_n)                       hi_q[k] <= 31'h1;
      else if (we && idx == IW'(k))     hi_q[k] <= wdata_hi;
    end
  end
endmodule

// File: rtl/gpio_regbank.sv
module gpio_regbank
  import gpio_regbank_pkg::*;
#(
  parameter int AW    = 12,
  parameter int NPINS = 32,
  localparam int IW   = (NPINS > 1) ? $clog2(NPINS) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  input  logic                req_write,
  input  logic [AW-1:0]       req_addr,
  input  logic [31:0]         req_wdata,
  input  logic [NPINS-1:0]    pin_in,
  output logic                rsp_valid,
  output logic [31:0]         rsp_rdata,
  output logic                rsp_err,
  output logic [NPINS-1:0]    out_level,
  output logic [NPINS-1:0]    dir_mask,
  output logic [NPINS*32-1:0] cfg_words
);
  sel_e                   sel;
  logic [IW-1:0]          cfg_idx;
  logic                   wr, bad;
  op_e                    op_out, op_dir;
  logic                   cfg_we;
  logic [NPINS-1:0]       in_q;
  logic [NPINS-1:0][30:0] cfg_hi;
  logic [31:0]            rd_val;

  gpio_addr_decode #(.AW(AW), .NPINS(NPINS)) u_dec (
    .addr(req_addr), .sel(sel), .cfg_idx(cfg_idx)
  );

  assign wr     = req_valid && req_write;
  assign cfg_we = wr && (sel == SEL_CFG);
  assign bad    = (sel == SEL_NONE) || (req_write && sel == SEL_IN);

  always_comb begin
    op_out = OP_HOLD;
    op_dir = OP_HOLD;
    if (wr) begin
      case (sel)
        SEL_OUT:    op_out = OP_LOAD;
        SEL_OUTSET: op_out = OP_SET;
        SEL_OUTCLR: op_out = OP_CLR;
        SEL_DIR:    op_dir = OP_LOAD;
        SEL_DIRSET: op_dir = OP_SET;
        SEL_DIRCLR: op_dir = OP_CLR;
        default: ;
      endcase
    end
  end

  gpio_setclr_reg #(.W(NPINS)) u_out (
    .clk(clk), .rst_n(rst_n), .op(op_out), .data(req_wdata[NPINS-1:0]),
    .bit_we(1'b0), .bit_idx('0), .bit_val(1'b0), .q(out_level)
  );

  // The direction bit of each configuration word is this register's bit.
  gpio_setclr_reg #(.W(NPINS)) u_dir (
    .clk(clk), .rst_n(rst_n), .op(op_dir), .data(req_wdata[NPINS-1:0]),
    .bit_we(cfg_we), .bit_idx(cfg_idx), .bit_val(req_wdata[0]), .q(dir_mask)
  );

  gpio_cfg_array #(.NPINS(NPINS)) u_cfg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .idx(cfg_idx),
    .wdata_hi(req_wdata[31:1]), .hi_q(cfg_hi)
  );

  for (genvar k = 0; k < NPINS; k++) begin : g_cfg_out
    assign cfg_words[32*k +: 32] = {cfg_hi[k], dir_mask[k]};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) in_q <= '0;
    else        in_q <= pin_in;
  end

  always_comb begin
    case (sel)
      SEL_OUT, SEL_OUTSET, SEL_OUTCLR: rd_val = 32'(out_level);
      SEL_DIR, SEL_DIRSET, SEL_DIRCLR: rd_val = 32'(dir_mask);
      SEL_IN:                          rd_val = 32'(in_q);
      SEL_CFG:                         rd_val = {cfg_hi[cfg_idx], dir_mask[cfg_idx]};
      default:                         rd_val = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      rsp_err   <= 1'b0;
    end else begin
      rsp_valid <= req_valid;
      rsp_err   <= req_valid && bad;
      rsp_rdata <= (req_valid && !req_write) ? rd_val : '0;
    end
  end

  assert_rsp_follows_R10: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  assert_no_rsp_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!rsp_valid && !rsp_err));
  assert_bad_write_inert_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && bad) |=> ($stable(out_level) && $stable(dir_mask) && $stable(cfg_words)));
  assert_bad_read_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write && sel == SEL_NONE) |=> (rsp_err && rsp_rdata == '0));
  assert_cfg_to_dir_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> (dir_mask[$past(cfg_idx)] == $past(req_wdata[0])));
  assert_dir_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && sel == SEL_DIR) |=> (dir_mask == $past(req_wdata[NPINS-1:0])));
endmodule

// File: tb/gpio_regbank_tb.sv
module gpio_regbank_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [11:0] req_addr = '0;
  logic [31:0] req_wdata = '0, pin_in = '0;
  logic        rsp_valid, rsp_err;
  logic [31:0] rsp_rdata, out_level, dir_mask;
  logic [1023:0] cfg_words;

  int total = 0, bad = 0, cycles = 0;
  logic [31:0] m_out, m_dir;
  logic [31:0] m_cfg [32];

  always #5 clk = ~clk;

  gpio_regbank dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .pin_in(pin_in),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
    .out_level(out_level), .dir_mask(dir_mask), .cfg_words(cfg_words)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles == 150000) begin
      total = total + 1; bad = bad + 1;
      $display("FAIL watchdog act=%0d exp=<150000", cycles);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    total = total + 1;
    if (act !== exp) begin
      bad = bad + 1;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic bit is_cfg(input logic [11:0] a);
    return a >= 12'h700 && a <= 12'h77C && a[1:0] == 2'b00;
  endfunction

  function automatic logic [31:0] m_rd(input logic [11:0] a);
    case (a)
      12'h504, 12'h508, 12'h50C: return m_out;
      12'h514, 12'h518, 12'h51C: return m_dir;
      default: return is_cfg(a) ? m_cfg[(a - 12'h700) >> 2] : 32'h0;
    endcase
  endfunction

  function automatic bit m_bad(input logic [11:0] a, input bit w);
    if (is_cfg(a)) return 0;
    case (a)
      12'h504, 12'h508, 12'h50C, 12'h514, 12'h518, 12'h51C: return 0;
      12'h510: return w;
      default: return 1;
    endcase
  endfunction

  task automatic sync_dir_cfg();
    for (int k = 0; k < 32; k++) m_cfg[k][0] = m_dir[k];
  endtask

  task automatic check_ports(input string tag);
    chk(out_level, m_out, {tag, " R2 out_level"});
    chk(dir_mask, m_dir, {tag, " R4 dir_mask"});
    for (int k = 0; k < 32; k++) chk(cfg_words[32*k +: 32], m_cfg[k], {tag, " R5 R6 cfg_words"});
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d, input string tag);
    bit e;
    e = m_bad(a, 1);
    case (a)
      12'h504: m_out = d;
      12'h508: m_out = m_out | d;
      12'h50C: m_out = m_out & ~d;
      12'h514: begin m_dir = d;          sync_dir_cfg(); end
      12'h518: begin m_dir = m_dir | d;  sync_dir_cfg(); end
      12'h51C: begin m_dir = m_dir & ~d; sync_dir_cfg(); end
      default: if (is_cfg(a)) begin
        m_cfg[(a - 12'h700) >> 2] = d;
        m_dir[(a - 12'h700) >> 2] = d[0];
      end
    endcase
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
    chk(32'(rsp_valid), 32'h1, {tag, " R10 valid"});
    chk(32'(rsp_err), 32'(e), {tag, " R9 err"});
    check_ports(tag);
  endtask

  task automatic rd(input logic [11:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    chk(32'(rsp_valid), 32'h1, {tag, " R10 valid"});
    chk(32'(rsp_err), 32'(m_bad(a, 0)), {tag, " R9 err"});
    chk(rsp_rdata, exp, tag);
  endtask

  task automatic read_all(input string tag);
    foreach (m_cfg[k]) rd(12'h700 + 12'(4*k), m_cfg[k], {tag, " R5 R7 cfg"});
    rd(12'h514, m_dir, {tag, " R4 dir"});
    rd(12'h518, m_dir, {tag, " R4 dirset rd"});
    rd(12'h51C, m_dir, {tag, " R4 dirclr rd"});
  endtask

  function automatic logic [31:0] pat(input int i);
    logic [31:0] x;
    x = 32'h1234_5678 * (i + 1) + 32'h9E37_79B9 * i;
    case (i % 4)
      0: return 32'h0;
      1: return 32'hFFFF_FFFF;
      2: return 32'h1 << (i % 32);
      default: return x;
    endcase
  endfunction

  initial begin
    m_out = '0; m_dir = '0;
    foreach (m_cfg[k]) m_cfg[k] = 32'h2;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check_ports("R1 reset");
    rd(12'h504, 32'h0, "R1 out");
    rd(12'h510, 32'h0, "R1 in");
    read_all("R1");

    // R2 R3 output family
    for (int i = 0; i < 12; i++) begin
      wr(12'h504, pat(i), "R2 load");
      wr(12'h508, pat(i + 5), "R2 set");
      wr(12'h50C, pat(i + 7), "R2 clr");
      rd(12'h504, m_out, "R3 rd out");
      rd(12'h508, m_out, "R3 rd outset");
      rd(12'h50C, m_out, "R3 rd outclr");
    end

    // R4 R5 direction family, cfg bit 0 follows
    for (int i = 0; i < 8; i++) begin
      wr(12'h514, pat(i + 3), "R4 load");
      read_all("R5 after load");
      wr(12'h518, pat(i + 9), "R4 set");
      wr(12'h51C, pat(i + 2), "R4 clr");
      read_all("R5 after setclr");
    end

    // R6 R7 per-pin config words
    for (int k = 0; k < 32; k++) begin
      wr(12'h700 + 12'(4*k), pat(k + 3) ^ (32'h1 << k), "R6 cfg wr");
      rd(12'h514, m_dir, "R6 dir after cfg");
    end
    read_all("R7 sweep");
    for (int k = 31; k >= 0; k--) wr(12'h700 + 12'(4*k), {pat(k)[31:1], ~m_dir[k]}, "R6 flip");
    read_all("R6 flip");

    // R8 input register
    for (int i = 0; i < 8; i++) begin
      pin_in = pat(i + 1) ^ 32'h0F0F_00FF;
      @(negedge clk); @(negedge clk);
      rd(12'h510, pin_in, "R8 in");
    end
    wr(12'h510, 32'hFFFF_FFFF, "R8 write to in");
    rd(12'h510, pin_in, "R8 in unchanged");

    // R9 unmapped / misaligned
    wr(12'h500, 32'hFFFF_FFFF, "R9 unmapped");
    wr(12'h506, 32'hFFFF_FFFF, "R9 misaligned");
    wr(12'h780, 32'hFFFF_FFFF, "R9 past cfg");
    wr(12'h702, 32'hFFFF_FFFF, "R9 cfg misaligned");
    wr(12'h000, 32'hFFFF_FFFF, "R9 zero");
    rd(12'h500, 32'h0, "R9 rd unmapped");
    rd(12'h781, 32'h0, "R9 rd misaligned");
    rd(12'hFFC, 32'h0, "R9 rd top");
    read_all("R9 state kept");
    rd(12'h504, m_out, "R9 out kept");

    // R10 idle: no response without a request
    @(negedge clk);
    chk(32'(rsp_valid), 32'h0, "R10 idle");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule